// File: doc/BRIEF.md
# SD Command Issuer with Response Capture

This block takes one 16-bit command word written by the host controller's register logic. It splits the word into a command index, an init flag, a response kind, a busy flag, a command class and a data direction. It then hands the index and a 32-bit argument to the card side as a one-cycle request. When the response kind calls for a reply, it waits for the card's answer. The card side returns the answer as up to sixteen bytes together with a byte count.

When the answer arrives, or when the wait runs out, the block checks the byte count against the response kind. It stores the bytes into eight 16-bit response registers and updates the status word. The status word carries end-of-command, stop-command, timeout, card-busy and card-error flags. Serial line signalling and CRC are not part of this block.

Software polls or clears the status word through a write-one-to-clear input. Software reads the response registers from a flat 128-bit output. The data path learns from two outputs whether a transfer was started and in which direction.

Top module: `sd_cmd_issuer`

## Requirements
- R1: An accepted command word drives `card_req` high for exactly the following cycle, with `card_idx` equal to word bits 5:0 and `card_arg` equal to `cmd_arg` as sampled at the write.
- R2: A command write while `en` is low, or while `busy` is high, is ignored: no request, no change to the response registers, the transfer outputs or the status word.
- R3: Every accepted command word clears all eight response registers in the cycle after the write.
- R4: A word with the init flag (bit 7) set and index 0 issues no request. It sets status bit 0 and leaves the other status bits unchanged.
- R5: Command class 3 (bits 13:12) sets `xfer_active` and copies bit 15 into `xfer_dir`. Classes 0 to 2 clear `xfer_active`.
- R6: The response kind is held in bits 10:8: 1 for a 4-byte status, 2 for 16 bytes, 3 for an operating-conditions reply, and 6 for a published address. A reply shorter than 4 bytes (16 for kind 2), or no reply within `cto`+1 waiting cycles, sets status bit 7. It also clears bits 14 and 11:0, leaves bit 0 clear and leaves the response registers at zero.
- R7: For kind 1, with or without the busy flag (bit 11), the first four reply bytes form a big-endian word. That word is ANDed with 0xFDF90000, and any hit sets status bit 14.
- R8: For kind 3, reply bit 31 set clears status bits 12:0. Reply bit 31 clear sets status bit 12.
- R9: For kind 6, reply bytes 2 and 3 form a big-endian halfword. That halfword is ANDed with 0xE008, and any hit sets status bit 14.
- R10: Reply bytes are paired big-endian into words, and word i goes to response register 7−i (register k is `rsp_regs[16k+15:16k]`). Kind 2 stores all eight words. Kinds 1, 3 and 6 store words 0 and 1, and the rest stay zero.
- R11: On a completion without timeout and without a card-error hit, status bits 14 and 11:0 are cleared. Then bit 0 is set, and bits 0 and 2 are set when the index is 12. Kinds 0, 4, 5 and 7 complete in the cycle after the request, without waiting.
- R12: `busy` is high from the cycle after an accepted request-issuing write until status bit 0 or bit 7 is set.
- R13: A `stat_clr_we` cycle clears the status bits set in `stat_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable; commands are dropped when low |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument |
| cto | input | TO_W | Response wait limit in cycles, minus one |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr | input | 16 | Status bits to clear |
| card_req | output | 1 | One-cycle command request to the card side |
| card_idx | output | 6 | Command index of the request |
| card_arg | output | 32 | Argument of the request |
| card_rsp_valid | input | 1 | Card reply strobe |
| card_rsp_len | input | 5 | Reply length in bytes (0 to 16) |
| card_rsp_data | input | 128 | Reply bytes, byte 0 in bits 127:120 |
| busy | output | 1 | Command in flight |
| status | output | 16 | Status word |
| rsp_regs | output | 128 | Eight response registers, register k in bits 16k+15:16k |
| xfer_active | output | 1 | Data transfer started by the last command |
| xfer_dir | output | 1 | Direction of that transfer |

## Verification
Every response kind, 0 through 7, is tried with reply lengths of 0, 3, 4, 15 and 16 bytes. These runs use two indices, 12 and 17, the second with the busy flag set. The sweep separates short-reply timeouts from good completions, shows the stop-command extra bit, and shows which words each kind stores. Byte patterns vary across the sweep, so the kind 1 and kind 6 error masks are hit on some runs and missed on others. A reply that never comes, and one that arrives in the last allowed cycle, pin down the wait limit. Kind 3 is run twice in a row without clearing, which shows that its busy bit both sets and clears status bit 12. Writes while disabled and while busy, the init command and the class-3 direction latch each get their own runs.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int          TO_W        = 8,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cmd_we,
  input  logic [15:0]     cmd_word,
  input  logic [31:0]     cmd_arg,
  input  logic [TO_W-1:0] cto,
  input  logic            stat_clr_we,
  input  logic [15:0]     stat_clr,
  output logic            card_req,
  output logic [5:0]      card_idx,
  output logic [31:0]     card_arg,
  input  logic            card_rsp_valid,
  input  logic [4:0]      card_rsp_len,
  input  logic [127:0]    card_rsp_data,
  output logic            busy,
  output logic [15:0]     status,
  output logic [127:0]    rsp_regs,
  output logic            xfer_active,
  output logic            xfer_dir
);
  localparam logic [15:0] KEEP_MASK = 16'hB000;
  localparam logic [15:0] R3_KEEP   = 16'hE000;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t          st;
  logic [5:0]      idx_q;
  logic [2:0]      rt_q;
  logic [31:0]     arg_q;
  logic [TO_W-1:0] cnt;
  logic [15:0]     stat_q;
  logic [127:0]    rsp_q;
  logic            xa_q, xd_q;

  logic        unused_bits;
  assign unused_bits = ^{cmd_word[14], cmd_word[11], cmd_word[6]};

  wire accept  = en && cmd_we && (st == S_IDLE);
  wire init0   = cmd_word[7] && (cmd_word[5:0] == 6'd0);
  wire has_rsp = (rt_q == 3'd1) || (rt_q == 3'd2) || (rt_q == 3'd3) || (rt_q == 3'd6);
  wire [4:0] need_len  = (rt_q == 3'd2) ? 5'd16 : 5'd4;
  wire       short_rsp = card_rsp_len < need_len;
  wire [15:0] base     = stat_clr_we ? (stat_q & ~stat_clr) : stat_q;
  wire [15:0] fin_to   = (base & KEEP_MASK) | 16'h0080;
  wire [127:0] rsp_new = (rt_q == 3'd2) ? card_rsp_data : {card_rsp_data[127:96], 96'd0};

  logic [15:0] r3_stat, fin_ok;
  logic        err;
  always_comb begin
    r3_stat = base;
    if (rt_q == 3'd3) r3_stat = card_rsp_data[127] ? (base & R3_KEEP) : (base | 16'h1000);
    err = ((rt_q == 3'd1) && |(card_rsp_data[127:96] & R1_ERR_MASK)) ||
          ((rt_q == 3'd6) && |(card_rsp_data[111:96] & R6_ERR_MASK));
    fin_ok = (err ? (r3_stat | 16'h4000) : (r3_stat & KEEP_MASK)) |
             ((idx_q == 6'd12) ? 16'h0005 : 16'h0001);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx_q <= '0; rt_q <= '0; arg_q <= '0; cnt <= '0;
      stat_q <= '0; rsp_q <= '0; xa_q <= 1'b0; xd_q <= 1'b0;
    end else begin
      stat_q <= base;
      unique case (st)
        S_IDLE: if (accept) begin
          rsp_q <= '0;
          idx_q <= cmd_word[5:0];
          rt_q  <= cmd_word[10:8];
          arg_q <= cmd_arg;
          if (init0) stat_q <= base | 16'h0001;
          else begin
            st <= S_REQ;
            if (cmd_word[13:12] == 2'd3) begin
              xa_q <= 1'b1;
              xd_q <= cmd_word[15];
            end else xa_q <= 1'b0;
          end
        end
        S_REQ: if (has_rsp) begin
          st  <= S_WAIT;
          cnt <= cto;
        end else begin
          st     <= S_IDLE;
          stat_q <= fin_ok;
        end
        S_WAIT: if (card_rsp_valid) begin
          st <= S_IDLE;
          if (short_rsp) stat_q <= fin_to;
          else begin
            stat_q <= fin_ok;
            rsp_q  <= rsp_new;
          end
        end else if (cnt == '0) begin
          st     <= S_IDLE;
          stat_q <= fin_to;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign card_req    = (st == S_REQ);
  assign card_idx    = idx_q;
  assign card_arg    = arg_q;
  assign busy        = (st != S_IDLE);
  assign status      = stat_q;
  assign rsp_regs    = rsp_q;
  assign xfer_active = xa_q;
  assign xfer_dir    = xd_q;

  assert_req_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |=> !card_req);
  assert_req_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_we && !busy && !init0) |=> (card_req && card_idx == $past(cmd_word[5:0])
                                           && card_arg == $past(cmd_arg)));
  assert_ignored_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && cmd_we && !busy) |=> (!busy && $stable(rsp_regs) && $stable(xfer_active)));
  assert_rsp_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_we && !busy) |=> (rsp_regs == '0));
  assert_init_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_we && !busy && init0) |=> (!card_req && !busy && status[0]));
  assert_timeout_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> (!status[0] && rsp_regs == '0));
  assert_busy_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status[0] || status[7]));
endmodule

// File: tb/sd_cmd_issuer_tb.sv
module sd_cmd_issuer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, cmd_we = 1'b0, stat_clr_we = 1'b0, card_rsp_valid = 1'b0;
  logic [15:0] cmd_word = '0, stat_clr = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  cto = 8'd5;
  logic [4:0]  card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic card_req, busy, xfer_active, xfer_dir;
  logic [5:0] card_idx;
  logic [31:0] card_arg;
  logic [15:0] status;
  logic [127:0] rsp_regs;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_issuer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cmd_arg(cmd_arg), .cto(cto), .stat_clr_we(stat_clr_we), .stat_clr(stat_clr),
    .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_len(card_rsp_len),
    .card_rsp_data(card_rsp_data), .busy(busy), .status(status), .rsp_regs(rsp_regs),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit kind_waits(input logic [2:0] rt);
    return rt == 3'd1 || rt == 3'd2 || rt == 3'd3 || rt == 3'd6;
  endfunction

  function automatic logic [15:0] model_stat(input logic [15:0] s0, input logic [2:0] rt,
      input logic [5:0] idx, input logic [4:0] len, input logic [127:0] d);
    logic [15:0] s;
    bit hit;
    if (kind_waits(rt) && len < ((rt == 3'd2) ? 5'd16 : 5'd4))
      return (s0 & 16'hB000) | 16'h0080;
    s = s0;
    if (rt == 3'd3) begin
      if (d[127]) s = s & 16'hE000;
      else s = s | 16'h1000;
    end
    hit = (rt == 3'd1 && (d[127:96] & 32'hFDF9_0000) != 0) ||
          (rt == 3'd6 && (d[111:96] & 16'hE008) != 0);
    s = hit ? (s | 16'h4000) : (s & 16'hB000);
    return s | ((idx == 6'd12) ? 16'h0005 : 16'h0001);
  endfunction

  function automatic logic [127:0] model_rsp(input logic [2:0] rt, input logic [4:0] len,
      input logic [127:0] d);
    logic [127:0] r = '0;
    if (!kind_waits(rt)) return r;
    if (rt == 3'd2) begin
      if (len < 5'd16) return r;
      for (int i = 0; i < 8; i++) r[16*(7-i) +: 16] = d[127-16*i -: 16];
    end else begin
      if (len < 5'd4) return r;
      for (int i = 0; i < 2; i++) r[16*(7-i) +: 16] = d[127-16*i -: 16];
    end
    return r;
  endfunction

  task automatic clear_status();
    @(negedge clk); stat_clr_we = 1'b1; stat_clr = 16'hFFFF;
    @(negedge clk); stat_clr_we = 1'b0; stat_clr = '0;
  endtask

  task automatic run_cmd(input logic [15:0] w, input logic [31:0] a, input logic [4:0] len,
      input logic [127:0] d, input string req);
    logic [15:0] s0;
    logic [2:0] rt = w[10:8];
    s0 = status;
    @(negedge clk); cmd_we = 1'b1; cmd_word = w; cmd_arg = a;
    @(negedge clk); cmd_we = 1'b0;
    chk(card_req === 1'b1, "R1 req", 128'(card_req), 128'd1);
    chk(card_idx === w[5:0] && card_arg === a, "R1 idx/arg", {card_idx, card_arg}, {w[5:0], a});
    chk(rsp_regs === '0, "R3 rsp cleared", rsp_regs, 128'd0);
    chk(busy === 1'b1, "R12 busy during issue", 128'(busy), 128'd1);
    if (kind_waits(rt)) begin
      @(negedge clk);
      chk(card_req === 1'b0, "R1 req single", 128'(card_req), 128'd0);
      card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = d;
      @(negedge clk); card_rsp_valid = 1'b0;
    end else @(negedge clk);
    chk(status === model_stat(s0, rt, w[5:0], len, d), {req, " status"}, 128'(status),
        128'(model_stat(s0, rt, w[5:0], len, d)));
    chk(rsp_regs === model_rsp(rt, len, d), "R10 rsp store", rsp_regs, model_rsp(rt, len, d));
    chk(busy === 1'b0, "R12 busy end", 128'(busy), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] d;
    logic [15:0] w;
    logic [15:0] s_before;
    logic [127:0] r_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status === '0 && rsp_regs === '0 && busy === 1'b0 && card_req === 1'b0 && xfer_active === 1'b0,
        "R12 reset state", {status, rsp_regs[15:0], busy, card_req, xfer_active}, '0);
    en = 1'b1;

    // R6 R7 R9 R10 R11: sweep every response kind, lengths and two indices
    for (int rt = 0; rt < 8; rt++)
      for (int li = 0; li < 5; li++)
        for (int k = 0; k < 2; k++) begin
          automatic logic [4:0] lens[5] = '{5'd0, 5'd3, 5'd4, 5'd15, 5'd16};
          automatic logic [5:0] ix = (k == 0) ? 6'd12 : 6'd17;
          for (int b = 0; b < 16; b++) d[127-8*b -: 8] = 8'(rt*29 + li*7 + b*13 + k*91 + 3);
          w = {1'b0, 1'b0, 2'd1, 1'(k), 3'(rt), 1'b0, 1'b0, ix};
          clear_status();
          run_cmd(w, {w, ~w}, lens[li], d, "R11 sweep");
        end

    // R7: clean status word vs error word, with busy flag (R1b)
    clear_status();
    run_cmd(16'h0905, 32'h1, 5'd4, {32'h0000_0900, 96'd0}, "R7 clean");
    chk(status[14] === 1'b0, "R7 no err", 128'(status[14]), 128'd0);
    clear_status();
    run_cmd(16'h0905, 32'h1, 5'd4, {32'h0008_0000, 96'd0}, "R7 err");
    chk(status[14] === 1'b1, "R7 err hit", 128'(status[14]), 128'd1);

    // R9: address reply with mask hit in byte 3
    clear_status();
    run_cmd(16'h0603, 32'h0, 5'd4, {32'hABCD_0008, 96'd0}, "R9 err");
    chk(status === 16'h4001, "R9 status", 128'(status), 128'h4001);

    // R8: not-ready reply sets bit12, then ready reply clears it
    clear_status();
    run_cmd(16'h0329, 32'h0, 5'd4, {32'h00FF_8000, 96'd0}, "R8 notready");
    chk(status === 16'h1001, "R8 bit12 set", 128'(status), 128'h1001);
    run_cmd(16'h0329, 32'h0, 5'd4, {32'h80FF_8000, 96'd0}, "R8 ready");
    chk(status === 16'h0001, "R8 bit12 cleared", 128'(status), 128'h0001);

    // R13: write-one-to-clear of selected bits
    @(negedge clk); stat_clr_we = 1'b1; stat_clr = 16'h0001;
    @(negedge clk); stat_clr_we = 1'b0;
    chk(status === 16'h0000, "R13 clear", 128'(status), 128'h0);

    // R4: init with index 0
    @(negedge clk); stat_clr_we = 1'b1; stat_clr = 16'hFFFF;
    @(negedge clk); stat_clr_we = 1'b0;
    run_cmd(16'h0200, 32'h0, 5'd0, '0, "R6 seed"); // kind 2 timeout leaves bit7
    @(negedge clk); cmd_we = 1'b1; cmd_word = 16'h0080;
    @(negedge clk); cmd_we = 1'b0;
    chk(card_req === 1'b0 && busy === 1'b0, "R4 no req", {card_req, busy}, 2'b00);
    chk(status === 16'h0081, "R4 status", 128'(status), 128'h0081);

    // R5: class 3 latches direction, other class clears
    clear_status();
    run_cmd(16'hB111, 32'h5, 5'd4, '0, "R5 read");
    chk(xfer_active === 1'b1 && xfer_dir === 1'b1, "R5 start rd", {xfer_active, xfer_dir}, 2'b11);
    run_cmd(16'h3111, 32'h5, 5'd4, '0, "R5 write");
    chk(xfer_active === 1'b1 && xfer_dir === 1'b0, "R5 start wr", {xfer_active, xfer_dir}, 2'b10);
    run_cmd(16'h2111, 32'h5, 5'd4, '0, "R5 plain");
    chk(xfer_active === 1'b0, "R5 stop", 128'(xfer_active), 128'd0);

    // R2: disabled write ignored
    run_cmd(16'h0200, 32'h9, 5'd16, {8{16'h1234}}, "R2 seed");
    s_before = status; r_before = rsp_regs;
    en = 1'b0;
    @(negedge clk); cmd_we = 1'b1; cmd_word = 16'h3105;
    @(negedge clk); cmd_we = 1'b0;
    chk(card_req === 1'b0 && busy === 1'b0, "R2 off no req", {card_req, busy}, 2'b00);
    @(negedge clk);
    chk(status === s_before && rsp_regs === r_before && xfer_active === 1'b0, "R2 off no change",
        rsp_regs, r_before);
    en = 1'b1;

    // R2 R6 R12: wait limit; busy write ignored; timeout after cto+1 wait cycles
    cto = 8'd3;
    clear_status();
    @(negedge clk); cmd_we = 1'b1; cmd_word = 16'h0107; cmd_arg = 32'h77;
    @(negedge clk); cmd_we = 1'b0;
    @(negedge clk); cmd_we = 1'b1; cmd_word = 16'hB112;
    @(negedge clk); cmd_we = 1'b0;
    chk(card_req === 1'b0 && xfer_active === 1'b0, "R2 busy ignored", {card_req, xfer_active}, 2'b00);
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b1 && status === 16'h0, "R12 still waiting", {busy, status}, {1'b1, 16'h0});
    @(negedge clk);
    chk(busy === 1'b0 && status === 16'h0080, "R6 no reply timeout", {busy, status}, {1'b0, 16'h0080});
    chk(rsp_regs === '0, "R6 rsp zero", rsp_regs, 128'd0);
    @(negedge clk);
    chk(card_req === 1'b0, "R2 no late req", 128'(card_req), 128'd0);

    // R6: reply in last allowed wait cycle is accepted
    clear_status();
    @(negedge clk); cmd_we = 1'b1; cmd_word = 16'h0107; cmd_arg = 32'h78;
    @(negedge clk); cmd_we = 1'b0;
    repeat (4) @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = 5'd4; card_rsp_data = {32'h0000_0100, 96'd0};
    @(negedge clk); card_rsp_valid = 1'b0;
    chk(status === 16'h0001 && busy === 1'b0, "R6 last cycle ok", {busy, status}, {1'b0, 16'h0001});
    chk(rsp_regs[127:96] === 32'h0000_0100, "R10 last cycle store", rsp_regs, {32'h0000_0100, 96'd0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule